// File: doc/BRIEF.md
# Decimal Frequency Report Line Formatter

This block turns a binary frequency reading, given in kilohertz, plus a small channel index into one fixed-length line of ASCII text, for example `RO1=185465 kHz` followed by carriage return and line feed. The bytes go out one at a time on a valid/ready byte interface. That interface is meant to feed a UART transmitter running at 115200 bps with 8 data bits, no parity and one stop bit.

Conversion from binary to decimal is iterative. A shift-and-adjust engine handles one input bit per clock, so the block has no wide divider. A reading is taken only while the formatter is idle. A reading that arrives during conversion or transmission is discarded and a sticky overrun flag is set. An upstream source that alternates its channel index gets interleaved lines for the two oscillators in an endless sequence.

Top module: `fmt_freq_report`

## Requirements
- R1: After synchronous reset, `tx_valid_o`, `busy_o` and `overrun_o` are all 0.
- R2: Each line is 16 bytes in this order: 'R' (0x52), 'O' (0x4F), the channel digit, '=' (0x3D), six value digits, space (0x20), 'k' (0x6B), 'H' (0x48), 'z' (0x7A), 0x0D, 0x0A.
- R3: The channel digit is ASCII '1' (0x31) plus the channel index, so index 0 prints '1' and index 1 prints '2'.
- R4: The value is printed as exactly six decimal ASCII digits (0x30 to 0x39), most significant first, with leading zeros kept.
- R5: A reading above 999999 is printed as 999999.
- R6: A byte is transferred only on a clock edge where `tx_valid_o` and `tx_ready_i` are both 1. While `tx_ready_i` is 0, `tx_valid_o` stays 1 and `tx_data_o` stays unchanged.
- R7: A reading is accepted on an edge where `meas_valid_i` is 1 and `busy_o` is 0. `busy_o` then stays 1 until the edge that transfers the final line feed, and returns to 0 after that edge.
- R8: A reading presented while `busy_o` is 1 is dropped. The line in flight is unchanged, no extra line follows, and `overrun_o` becomes 1 and stays 1 until reset.
- R9: The first byte of a line is presented exactly VALUE_W+1 clock edges after the accepting edge (21 with defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| meas_valid_i | input | 1 | Reading present this cycle |
| meas_khz_i | input | VALUE_W | Reading in kHz, unsigned binary |
| meas_chan_i | input | CHAN_W | Channel index of the reading |
| tx_data_o | output | 8 | ASCII byte offered to the transmitter |
| tx_valid_o | output | 1 | `tx_data_o` holds a byte |
| tx_ready_i | input | 1 | Transmitter takes the byte this edge |
| busy_o | output | 1 | Line in conversion or transmission |
| overrun_o | output | 1 | Sticky: a reading was dropped |

## Verification
A wrong converter state appears at the ports as a wrong or non-decimal digit byte. It shows up within the first line after the fault, at byte positions five to ten. A wrong byte index shows as a shifted, shortened or lengthened line, so the bench checks every byte of every line against a value it computes itself. A wrong sequencer state shows as a line that never ends or starts too early. It also shows as `busy_o` failing to drop after the line feed, or as a first byte that comes out a cycle early or late. The bench catches these with an exact latency count and by watching for idle after each line. Stalled handshakes are checked on every cycle where ready is held low.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  localparam logic [7:0] CH_R     = 8'h52;
  localparam logic [7:0] CH_O     = 8'h4F;
  localparam logic [7:0] CH_EQ    = 8'h3D;
  localparam logic [7:0] CH_SP    = 8'h20;
  localparam logic [7:0] CH_K     = 8'h6B;
  localparam logic [7:0] CH_H     = 8'h48;
  localparam logic [7:0] CH_Z     = 8'h7A;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_LF    = 8'h0A;
  localparam logic [7:0] CH_ZERO  = 8'h30;
  localparam logic [7:0] CH_ONE   = 8'h31;
  localparam int         HEAD_LEN = 4;  // "RO", channel, '='
  localparam int         TAIL_LEN = 6;  // ' ', "kHz", CR, LF

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_SEND = 2'd2
  } fmt_state_e;
endpackage

// File: rtl/fmt_dabble.sv
module fmt_dabble #(
  parameter int VALUE_W = 20,
  parameter int NUM_DIG = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic                   start_i,
  input  logic [VALUE_W-1:0]     value_i,
  output logic                   done_o,
  output logic [NUM_DIG*4-1:0]   bcd_o
);
  localparam int BCD_W = NUM_DIG * 4;
  localparam int CNT_W = $clog2(VALUE_W + 1);

  logic [VALUE_W-1:0] bin_q;
  logic [BCD_W-1:0]   bcd_q;
  logic [BCD_W-1:0]   adj;
  logic [CNT_W-1:0]   cnt_q;
  logic               run_q;
  logic               done_q;

  // Add three to every digit of five or more before the shift
  for (genvar g = 0; g < NUM_DIG; g++) begin : g_adj
    always_comb begin
      if (bcd_q[g*4 +: 4] >= 4'd5) adj[g*4 +: 4] = bcd_q[g*4 +: 4] + 4'd3;
      else                         adj[g*4 +: 4] = bcd_q[g*4 +: 4];
    end

    p_digit_range_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |-> (bcd_o[g*4 +: 4] <= 4'd9));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      bin_q  <= '0;
      bcd_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        bin_q <= value_i;
        bcd_q <= '0;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        bcd_q <= {adj[BCD_W-2:0], bin_q[VALUE_W-1]};
        bin_q <= {bin_q[VALUE_W-2:0], 1'b0};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(VALUE_W - 1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign bcd_o  = bcd_q;

  p_done_single_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);
endmodule

// File: rtl/fmt_char_sel.sv
module fmt_char_sel
  import fmt_pkg::*;
#(
  parameter int NUM_DIG = 6,
  parameter int CHAN_W  = 1,
  parameter int IDX_W   = 5
) (
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [CHAN_W-1:0]    chan_i,
  input  logic [NUM_DIG*4-1:0] bcd_i,
  output logic [7:0]           char_o
);
  localparam int DIG_END = HEAD_LEN + NUM_DIG;

  always_comb begin
    int i;
    int d;
    i = int'(idx_i);
    d = 0;
    char_o = 8'h00;
    if (i == 0)            char_o = CH_R;
    else if (i == 1)       char_o = CH_O;
    else if (i == 2)       char_o = CH_ONE + 8'(chan_i);
    else if (i == 3)       char_o = CH_EQ;
    else if (i < DIG_END) begin
      d = DIG_END - 1 - i;  // most significant digit first
      char_o = CH_ZERO + {4'b0000, bcd_i[d*4 +: 4]};
    end
    else if (i == DIG_END)     char_o = CH_SP;
    else if (i == DIG_END + 1) char_o = CH_K;
    else if (i == DIG_END + 2) char_o = CH_H;
    else if (i == DIG_END + 3) char_o = CH_Z;
    else if (i == DIG_END + 4) char_o = CH_CR;
    else if (i == DIG_END + 5) char_o = CH_LF;
  end
endmodule

// File: rtl/fmt_freq_report.sv
module fmt_freq_report
  import fmt_pkg::*;
#(
  parameter int VALUE_W = 20,
  parameter int NUM_DIG = 6,
  parameter int CHAN_W  = 1
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               meas_valid_i,
  input  logic [VALUE_W-1:0] meas_khz_i,
  input  logic [CHAN_W-1:0]  meas_chan_i,
  output logic [7:0]         tx_data_o,
  output logic               tx_valid_o,
  input  logic               tx_ready_i,
  output logic               busy_o,
  output logic               overrun_o
);
  localparam int          LINE_LEN = HEAD_LEN + NUM_DIG + TAIL_LEN;
  localparam int          IDX_W    = $clog2(LINE_LEN + 1);
  localparam logic [63:0] MAXV     = 64'(10 ** NUM_DIG) - 64'd1;
  localparam logic [63:0] RAWMAX   = (64'd1 << VALUE_W) - 64'd1;

  fmt_state_e         state_q;
  logic [CHAN_W-1:0]  chan_q;
  logic [IDX_W-1:0]   idx_q;
  logic [IDX_W-1:0]   sel_idx;
  logic [7:0]         data_q;
  logic               valid_q;
  logic               ovr_q;
  logic [VALUE_W-1:0] value_clamped;
  logic               accept;
  logic               conv_done;
  logic [NUM_DIG*4-1:0] bcd;
  logic [7:0]         next_char;

  // Clamp only when the input width can exceed the printable range
  if (RAWMAX > MAXV) begin : g_sat
    assign value_clamped = (64'(meas_khz_i) > MAXV) ? MAXV[VALUE_W-1:0] : meas_khz_i;
  end else begin : g_nosat
    assign value_clamped = meas_khz_i;
  end

  assign accept = (state_q == ST_IDLE) && meas_valid_i;

  fmt_dabble #(.VALUE_W(VALUE_W), .NUM_DIG(NUM_DIG)) i_dabble (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (accept),
    .value_i (value_clamped),
    .done_o  (conv_done),
    .bcd_o   (bcd)
  );

  assign sel_idx = (state_q == ST_CONV) ? '0 : idx_q + 1'b1;

  fmt_char_sel #(.NUM_DIG(NUM_DIG), .CHAN_W(CHAN_W), .IDX_W(IDX_W)) i_char (
    .idx_i  (sel_idx),
    .chan_i (chan_q),
    .bcd_i  (bcd),
    .char_o (next_char)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= ST_IDLE;
      chan_q  <= '0;
      idx_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (meas_valid_i && state_q != ST_IDLE) ovr_q <= 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (meas_valid_i) begin
            chan_q  <= meas_chan_i;
            state_q <= ST_CONV;
          end
        end
        ST_CONV: begin
          if (conv_done) begin
            idx_q   <= '0;
            data_q  <= next_char;
            valid_q <= 1'b1;
            state_q <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (tx_ready_i) begin
            if (idx_q == IDX_W'(LINE_LEN - 1)) begin
              valid_q <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              idx_q  <= idx_q + 1'b1;
              data_q <= next_char;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_data_o  = data_q;
  assign tx_valid_o = valid_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign overrun_o  = ovr_q;

  p_hold_stall_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));
  p_first_char_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(tx_valid_o) |-> tx_data_o == CH_R);
  p_valid_busy_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    tx_valid_o |-> busy_o);
  p_idle_after_lf_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    tx_valid_o && tx_ready_i && tx_data_o == CH_LF |=> !busy_o);
  p_overrun_set_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_o && meas_valid_i |=> overrun_o);
  p_overrun_sticky_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    overrun_o |=> overrun_o);
endmodule

// File: tb/test_fmt_freq_report.sv
module test_fmt_freq_report;
  localparam int CLK_PERIOD = 10;
  localparam int VALUE_W    = 20;
  localparam int LINE_LEN   = 16;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               meas_valid = 1'b0;
  logic [VALUE_W-1:0] meas_khz = '0;
  logic [0:0]         meas_chan = '0;
  logic [7:0]         tx_data;
  logic               tx_valid;
  logic               tx_ready = 1'b0;
  logic               busy;
  logic               overrun;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fmt_freq_report #(.VALUE_W(VALUE_W), .NUM_DIG(6), .CHAN_W(1)) i_fmt_freq_report (
    .clk_i        (clk),
    .rst_i        (rst),
    .meas_valid_i (meas_valid),
    .meas_khz_i   (meas_khz),
    .meas_chan_i  (meas_chan),
    .tx_data_o    (tx_data),
    .tx_valid_o   (tx_valid),
    .tx_ready_i   (tx_ready),
    .busy_o       (busy),
    .overrun_o    (overrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_char(input int i, input int chan, input int val);
    int v;
    int p;
    v = (val > 999999) ? 999999 : val;
    case (i)
      0: return 8'h52;
      1: return 8'h4F;
      2: return 8'(8'h31 + chan);
      3: return 8'h3D;
      10: return 8'h20;
      11: return 8'h6B;
      12: return 8'h48;
      13: return 8'h7A;
      14: return 8'h0D;
      15: return 8'h0A;
      default: begin
        p = 9 - i;
        return 8'(8'h30 + (v / (10 ** p)) % 10);
      end
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    tx_ready = 1'b0;
    meas_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_meas(input int chan, input int val);
    @(negedge clk);
    while (busy) @(negedge clk);
    meas_valid = 1'b1;
    meas_khz   = VALUE_W'(val);
    meas_chan  = 1'(chan);
    @(negedge clk);
    meas_valid = 1'b0;
    check(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
  endtask

  // mode 0: ready always high; mode 1: ready high one cycle in three
  task automatic collect_check(input int mode, input int chan, input int val, input string req);
    int n = 0;
    int cyc = 0;
    logic [7:0] held = 8'h00;
    bit stalled = 0;
    bit rdy;
    while (n < LINE_LEN && cyc < 2000) begin
      if (stalled) begin
        check(tx_valid && tx_data == held, "R6 byte held while stalled",
              int'(tx_data), int'(held));
      end
      rdy = (mode == 0) ? 1'b1 : (cyc % 3 == 2);
      tx_ready = rdy;
      if (tx_valid) begin
        if (rdy) begin
          check(tx_data == exp_char(n, chan, val), req, int'(tx_data),
                int'(exp_char(n, chan, val)));
          n++;
          stalled = 0;
        end else begin
          held = tx_data;
          stalled = 1;
        end
      end else stalled = 0;
      cyc++;
      @(negedge clk);
    end
    tx_ready = 1'b0;
    check(n == LINE_LEN, "R2 line length", n, LINE_LEN);
    check(busy == 1'b0 && tx_valid == 1'b0, "R7 idle after line feed",
          int'({busy, tx_valid}), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(tx_valid == 0 && busy == 0 && overrun == 0, "R1 outputs during reset",
          int'({tx_valid, busy, overrun}), 0);
    do_reset();
    check(tx_valid == 0 && busy == 0 && overrun == 0, "R1 outputs after reset",
          int'({tx_valid, busy, overrun}), 0);
  endtask

  task automatic t_basic();
    send_meas(0, 185465);
    collect_check(0, 0, 185465, "R2 R4 line for channel index 0");
    send_meas(1, 193094);
    collect_check(0, 1, 193094, "R3 channel index 1 prints 2");
    check(overrun == 0, "R8 no overrun on clean traffic", int'(overrun), 0);
  endtask

  task automatic t_leading_zeros();
    send_meas(0, 42);
    collect_check(0, 0, 42, "R4 leading zeros kept");
    send_meas(1, 0);
    collect_check(0, 1, 0, "R4 zero value");
    send_meas(0, 999999);
    collect_check(0, 0, 999999, "R4 largest printable value");
  endtask

  task automatic t_saturate();
    send_meas(1, 1000000);
    collect_check(0, 1, 1000000, "R5 just above range clamps");
    send_meas(0, (1 << VALUE_W) - 1);
    collect_check(0, 0, (1 << VALUE_W) - 1, "R5 full-scale input clamps");
  endtask

  task automatic t_stall();
    send_meas(1, 507310);
    collect_check(1, 1, 507310, "R6 line under back-pressure");
  endtask

  task automatic t_latency();
    int k = 1;
    send_meas(0, 123456);
    while (!tx_valid && k < 200) begin
      @(negedge clk);
      k++;
    end
    check(k - 1 == VALUE_W + 1, "R9 first byte latency", k - 1, VALUE_W + 1);
    collect_check(0, 0, 123456, "R9 line after latency");
  endtask

  task automatic t_overrun();
    bit extra = 0;
    do_reset();
    send_meas(0, 314159);
    repeat (3) @(negedge clk);
    meas_valid = 1'b1;
    meas_khz   = VALUE_W'(271828);
    meas_chan  = 1'b1;
    @(negedge clk);
    meas_valid = 1'b0;
    check(overrun == 1'b1, "R8 overrun flag set", int'(overrun), 1);
    collect_check(0, 0, 314159, "R8 line in flight unchanged");
    repeat (60) begin
      @(negedge clk);
      if (tx_valid || busy) extra = 1;
    end
    check(extra == 0, "R8 dropped reading produces no line", int'(extra), 0);
    check(overrun == 1'b1, "R8 overrun stays set", int'(overrun), 1);
    do_reset();
    check(overrun == 1'b0, "R1 reset clears overrun", int'(overrun), 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_leading_zeros();
    t_saturate();
    t_stall();
    t_latency();
    t_overrun();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule